// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register file and interconnect of a small accumulator machine. All registers and the word memory share one 16-bit bus. A 3-bit source code decides which one of them drives the bus in a given cycle. Any register can take the bus value at the next clock edge when its load control is high. The address, program-counter, data, accumulator and temporary registers also have their own increment and clear controls.

The memory is addressed by the address register. It is read combinationally onto the bus and written from the bus on a clock edge. An 8-bit serial input register is filled one bit per shift and can be moved into the accumulator. An 8-bit output register takes the low byte of the accumulator. Instruction decode and sequencing live outside the block and drive all of the control inputs directly.

Top module: `bus_datapath`

## Requirements
- R1: After reset, every register (address, program counter, data, accumulator, instruction, temporary, input, output) reads zero.
- R2: The bus value follows the source code. 000 gives zero. 001 gives the address register, zero-extended. 010 gives the program counter, zero-extended. 011 gives the data register. 100 gives the accumulator. 101 gives the instruction register. 110 gives the temporary register. 111 gives the memory word at the current address when memory read is high, and zero when it is low.
- R3: A register whose load input is high holds the bus value after the next rising edge. The 12-bit address register and program counter keep only bus bits 11:0.
- R4: Increment adds one to the register. The 12-bit registers wrap from 0xFFF to 0, and the 16-bit registers wrap at 16 bits.
- R5: Clear sets the register to zero. If clear, load and increment are all high on one register, clear wins, then load, then increment.
- R6: When memory write is high, the bus value is stored at the word the address register points to. Selecting code 111 with memory read high later returns that word.
- R7: Each cycle with shift enable high, the input register moves left by one bit and takes the serial bit into bit 0. This makes the first bit shifted in the most significant bit after eight shifts.
- R8: When the accumulator loads with input-select high, it takes the input register zero-extended to 16 bits instead of the bus value.
- R9: When the output load is high, the output register takes accumulator bits 7:0 at the next edge.
- R10: A register whose controls are all low keeps its value, whatever the bus and the other registers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| mem_rd | input | 1 | Memory read enable for source 111 |
| mem_wr | input | 1 | Write bus into memory at the address register |
| ld_ar | input | 1 | Address register load |
| inc_ar | input | 1 | Address register increment |
| clr_ar | input | 1 | Address register clear |
| ld_pc | input | 1 | Program counter load |
| inc_pc | input | 1 | Program counter increment |
| clr_pc | input | 1 | Program counter clear |
| ld_dr | input | 1 | Data register load |
| inc_dr | input | 1 | Data register increment |
| clr_dr | input | 1 | Data register clear |
| ld_ac | input | 1 | Accumulator load |
| inc_ac | input | 1 | Accumulator increment |
| clr_ac | input | 1 | Accumulator clear |
| ac_from_in | input | 1 | Accumulator load takes the input register instead of the bus |
| ld_ir | input | 1 | Instruction register load |
| ld_tr | input | 1 | Temporary register load |
| inc_tr | input | 1 | Temporary register increment |
| clr_tr | input | 1 | Temporary register clear |
| ld_out | input | 1 | Output register load from the accumulator |
| in_shift | input | 1 | Input register shift enable |
| in_bit | input | 1 | Serial input bit |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| in_q | output | 8 | Input register |
| out_q | output | 8 | Output register |

## Verification
The serial input register is the only way data enters the block, so any value above one byte has to be built from increments. The 12-bit wrap and the truncation on address loads are the hardest to reach. The bench steps the address register through 4095 increments to reach 0xFFF. It then copies that value through the bus into the data register and increments it past bit 12. Loading the result into the program counter shows that only bits 11:0 are kept. Memory words are given distinct contents by writing two different registers at neighbouring addresses before any read, so that each read can be told apart.

// File: rtl/bus_datapath.sv
module bus_datapath #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_sel,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic          ld_ar,
  input  logic          inc_ar,
  input  logic          clr_ar,
  input  logic          ld_pc,
  input  logic          inc_pc,
  input  logic          clr_pc,
  input  logic          ld_dr,
  input  logic          inc_dr,
  input  logic          clr_dr,
  input  logic          ld_ac,
  input  logic          inc_ac,
  input  logic          clr_ac,
  input  logic          ac_from_in,
  input  logic          ld_ir,
  input  logic          ld_tr,
  input  logic          inc_tr,
  input  logic          clr_tr,
  input  logic          ld_out,
  input  logic          in_shift,
  input  logic          in_bit,
  output logic [DW-1:0] bus_q,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] tr_q,
  output logic [IW-1:0] in_q,
  output logic [IW-1:0] out_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_word;
  logic [DW-1:0] ac_src;

  assign mem_word = mem[ar_q];
  assign ac_src   = ac_from_in ? DW'(in_q) : bus_q;

  always_comb begin
    case (bus_sel)
      3'd1:    bus_q = DW'(ar_q);
      3'd2:    bus_q = DW'(pc_q);
      3'd3:    bus_q = dr_q;
      3'd4:    bus_q = ac_q;
      3'd5:    bus_q = ir_q;
      3'd6:    bus_q = tr_q;
      3'd7:    bus_q = mem_rd ? mem_word : '0;
      default: bus_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_wr) mem[ar_q] <= bus_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ar_q <= '0;
    else if (clr_ar) ar_q <= '0;
    else if (ld_ar)  ar_q <= bus_q[AW-1:0];
    else if (inc_ar) ar_q <= ar_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (clr_pc) pc_q <= '0;
    else if (ld_pc)  pc_q <= bus_q[AW-1:0];
    else if (inc_pc) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dr_q <= '0;
    else if (clr_dr) dr_q <= '0;
    else if (ld_dr)  dr_q <= bus_q;
    else if (inc_dr) dr_q <= dr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ac_q <= '0;
    else if (clr_ac) ac_q <= '0;
    else if (ld_ac)  ac_q <= ac_src;
    else if (inc_ac) ac_q <= ac_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ld_ir) ir_q <= bus_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tr_q <= '0;
    else if (clr_tr) tr_q <= '0;
    else if (ld_tr)  tr_q <= bus_q;
    else if (inc_tr) tr_q <= tr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_q <= '0;
    else if (in_shift) in_q <= {in_q[IW-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (ld_out) out_q <= ac_q[IW-1:0];
  end

  // R3
  dr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dr && !clr_dr) |=> dr_q == $past(bus_q));

  // R5
  ac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ac |=> ac_q == '0);

  // R4
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pc && !ld_pc && !clr_pc) |=> pc_q == $past(pc_q) + 1'b1);

  // R7
  in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |=> in_q == {$past(in_q[IW-2:0]), $past(in_bit)});

  // R9
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_out |=> out_q == $past(ac_q[IW-1:0]));

  // R10
  tr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_tr && !inc_tr && !clr_tr) |=> $stable(tr_q));
endmodule

// File: tb/bus_datapath_test.sv
module bus_datapath_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_sel;
  logic mem_rd, mem_wr, ld_ar, inc_ar, clr_ar, ld_pc, inc_pc, clr_pc;
  logic ld_dr, inc_dr, clr_dr, ld_ac, inc_ac, clr_ac, ac_from_in;
  logic ld_ir, ld_tr, inc_tr, clr_tr, ld_out, in_shift, in_bit;
  logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic [7:0]  in_q, out_q;
  int checks = 0, fails = 0;
  bit done = 0;

  bus_datapath uut (.*);

  always #4 clk = ~clk;

  task automatic idle();
    {bus_sel, mem_rd, mem_wr, ld_ar, inc_ar, clr_ar, ld_pc, inc_pc, clr_pc} = '0;
    {ld_dr, inc_dr, clr_dr, ld_ac, inc_ac, clr_ac, ac_from_in} = '0;
    {ld_ir, ld_tr, inc_tr, clr_tr, ld_out, in_shift, in_bit} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      in_shift = 1; in_bit = v[i];
      step();
    end
  endtask

  task automatic t_reset();
    check("R1 ar", 16'(ar_q), 0); check("R1 pc", 16'(pc_q), 0);
    check("R1 dr", dr_q, 0); check("R1 ac", ac_q, 0);
    check("R1 ir", ir_q, 0); check("R1 tr", tr_q, 0);
    check("R1 in", 16'(in_q), 0); check("R1 out", 16'(out_q), 0);
    check("R2 sel000", bus_q, 0);
  endtask

  task automatic t_input();
    shift_byte(8'hA5);
    check("R7 in after 8 shifts", 16'(in_q), 16'h00A5);
    ld_ac = 1; ac_from_in = 1; bus_sel = 3'd3;
    step();
    check("R8 ac from input", ac_q, 16'h00A5);
    bus_sel = 3'd4; #1;
    check("R2 sel100 ac", bus_q, 16'h00A5);
  endtask

  task automatic t_transfers();
    bus_sel = 3'd4; ld_dr = 1; step();
    check("R3 dr load", dr_q, 16'h00A5);
    bus_sel = 3'd3; #1; check("R2 sel011 dr", bus_q, 16'h00A5);
    ld_tr = 1; step();
    check("R3 tr load", tr_q, 16'h00A5);
    bus_sel = 3'd6; #1; check("R2 sel110 tr", bus_q, 16'h00A5);
    ld_ir = 1; step();
    check("R3 ir load", ir_q, 16'h00A5);
    bus_sel = 3'd5; #1; check("R2 sel101 ir", bus_q, 16'h00A5);
    ld_pc = 1; step();
    check("R3 pc load", 16'(pc_q), 16'h00A5);
    bus_sel = 3'd2; #1; check("R2 sel010 pc", bus_q, 16'h00A5);
  endtask

  task automatic t_inc_prio();
    inc_dr = 1; inc_tr = 1; step();
    check("R4 dr inc", dr_q, 16'h00A6);
    check("R4 tr inc", tr_q, 16'h00A6);
    bus_sel = 3'd4; clr_dr = 1; ld_dr = 1; inc_dr = 1; step();
    check("R5 clear wins", dr_q, 0);
    bus_sel = 3'd4; ld_dr = 1; inc_dr = 1; step();
    check("R5 load over inc", dr_q, 16'h00A5);
    inc_dr = 1; step();
    check("R4 dr inc again", dr_q, 16'h00A6);
  endtask

  task automatic t_memory();
    bus_sel = 3'd4; ld_ar = 1; step();
    check("R3 ar load", 16'(ar_q), 16'h00A5);
    bus_sel = 3'd1; #1; check("R2 sel001 ar", bus_q, 16'h00A5);
    bus_sel = 3'd3; mem_wr = 1; step();
    inc_ar = 1; step();
    bus_sel = 3'd4; mem_wr = 1; step();
    bus_sel = 3'd7; mem_rd = 1; #1;
    check("R6 read word A6", bus_q, 16'h00A5);
    mem_rd = 0; #1;
    check("R2 sel111 no read", bus_q, 0);
    bus_sel = 3'd2; ld_ar = 1; step();
    bus_sel = 3'd7; mem_rd = 1; #1;
    check("R6 read word A5", bus_q, 16'h00A6);
    ld_ir = 1; step();
    check("R3 ir from memory", ir_q, 16'h00A6);
  endtask

  task automatic t_output();
    ld_out = 1; step();
    check("R9 out load", 16'(out_q), 16'h00A5);
    shift_byte(8'h3C);
    ld_ac = 1; ac_from_in = 1; step();
    check("R8 ac new input", ac_q, 16'h003C);
    check("R10 out held", 16'(out_q), 16'h00A5);
    ld_out = 1; step();
    check("R9 out reload", 16'(out_q), 16'h003C);
    inc_ac = 1; step();
    check("R4 ac inc", ac_q, 16'h003D);
    clr_ac = 1; ld_ac = 1; step();
    check("R5 ac clear", ac_q, 0);
  endtask

  task automatic t_hold();
    for (int s = 0; s < 8; s++) begin
      bus_sel = 3'(s); mem_rd = 1; step();
    end
    check("R10 dr held", dr_q, 16'h00A6);
    check("R10 tr held", tr_q, 16'h00A6);
    check("R10 ir held", ir_q, 16'h00A6);
    check("R10 pc held", 16'(pc_q), 16'h00A5);
  endtask

  task automatic t_wrap();
    clr_ar = 1; step();
    for (int i = 0; i < 4095; i++) begin
      inc_ar = 1; step();
    end
    check("R4 ar at max", 16'(ar_q), 16'h0FFF);
    bus_sel = 3'd1; #1;
    check("R2 ar zero-extended", bus_q, 16'h0FFF);
    ld_dr = 1; step();
    inc_ar = 1; step();
    check("R4 ar wrap", 16'(ar_q), 0);
    inc_dr = 1; step();
    inc_dr = 1; step();
    check("R4 dr past 12 bits", dr_q, 16'h1001);
    bus_sel = 3'd3; ld_pc = 1; step();
    check("R3 pc low 12 bits", 16'(pc_q), 16'h0001);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_input();
    t_transfers();
    t_inc_prio();
    t_memory();
    t_output();
    t_hold();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule